// File: doc/BRIEF.md
# Stipple and Blit Raster Engine

This block speeds up drawing into an 8-bit-per-pixel frame buffer whose lines are 1024 pixels apart. A host reaches it through a 32-bit write port split into two command windows, picked by `reg_win`. In either window, a write whose byte address has bit 2 clear only latches a colour word. A write with bit 2 set starts a command aimed at the pixel given by the address itself (byte address shifted right by three).

The stipple window paints the latched colour into up to 32 consecutive pixels chosen by a 32-bit mask. The blit window handles a run of 1 to 32 pixels. The run is either filled with the latched colour or copied from a source pixel index carried in the data word. A source field of all ones selects the fill.

The engine walks a run one pixel per clock over a dual-port pixel memory with one cycle of read latency. While it walks, it stalls further commands but keeps accepting colour writes.

Top module: `raster_engine`

## Requirements
- R1: A full-word write with byte-address bit 2 clear stores bits 7:0 of the data as the latched colour and writes no pixel.
- R2: A full-word write with byte-address bit 2 set starts a command whose destination pixel is byte address bits 22:3, reduced modulo 2^PIX_AW.
- R3: With `reg_win` = 0 (stipple), data bit 31-k governs pixel dest+k for k = 0..31. A 1 writes the latched colour and a 0 leaves the pixel unchanged. A stipple keeps the engine busy for exactly 32 cycles.
- R4: With `reg_win` = 1 (blit), data bits 28:24 hold the run length minus one, so a run covers 1 to 32 pixels.
- R5: A blit whose data bits 23:0 equal 0xFFFFFF fills the run with the latched colour and is busy for exactly length cycles.
- R6: Any other blit copies pixel src+k to dest+k for k rising from 0, with src taken from bits 23:0. Overlapping runs give the result of that sequential order, so dest = src+1 replicates pixel src. A copy is busy for length+1 cycles.
- R7: A write whose byte enables `reg_be` are not all four set is ignored: neither the colour nor the memory changes and no command starts.
- R8: `reg_rdata` is zero at all times.
- R9: While busy, `reg_ready` is low whenever the address selects a command, and high for a colour address. A colour latched during a run affects only later commands.
- R10: Destination and source pixel indices, and the run offsets added to them, wrap modulo the memory depth 2^PIX_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_win | input | 1 | Window select: 0 stipple, 1 blit |
| reg_addr | input | REG_AW | Byte address inside the window |
| reg_be | input | 4 | Byte enables, all four needed |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Write accepted this cycle when high |
| reg_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | A run is in progress |
| mem_ren | output | 1 | Pixel read enable |
| mem_raddr | output | PIX_AW | Pixel read index |
| mem_rdata | input | 8 | Pixel read data, one cycle after `mem_ren` |
| mem_wen | output | 1 | Pixel write enable |
| mem_waddr | output | PIX_AW | Pixel write index |
| mem_wdata | output | 8 | Pixel write data |

## Verification
The bench drives stipples with sparse, dense, alternating, edge-only and pseudo-random masks. These patterns separate bit-to-pixel order mistakes from skipped-pixel mistakes. Fills sweep every length from 1 to 32, which exposes off-by-one errors in the length field and in the busy count. Copies run with source just above, just below and three pixels from the destination, and disjoint from it. Only overlapping runs show whether read-after-write forwarding keeps the sequential order. Destinations and sources near the top of memory, with high address bits set, and a source one short of the fill key check the wrap rule and exact fill detection.

// File: rtl/raster_engine.sv
module raster_engine #(
  parameter int PIX_AW = 16,
  parameter int REG_AW = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_win,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic              reg_ready,
  output logic [31:0]       reg_rdata,
  output logic              busy,
  output logic              mem_ren,
  output logic [PIX_AW-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wen,
  output logic [PIX_AW-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);

  localparam logic [23:0] FILL_KEY = 24'hFFFFFF;
  localparam int          CNT_W    = 6;

  typedef enum logic [1:0] {OP_STIP, OP_FILL, OP_COPY} op_t;

  op_t               op_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [4:0]        last_q;
  logic [PIX_AW-1:0] dst_q, src_q;
  logic [31:0]       mask_q;
  logic [7:0]        colour_q, run_col_q;
  logic              fwd_q;
  logic [7:0]        fwd_d_q;

  logic wr_ok, latch_go, cmd_go, done;
  logic [CNT_W-1:0] end_cnt;

  assign wr_ok     = reg_wr && (reg_be == 4'hF);
  assign latch_go  = wr_ok && !reg_addr[2];
  assign cmd_go    = wr_ok && reg_addr[2] && !busy_q;
  assign reg_ready = !(reg_addr[2] && busy_q);
  assign reg_rdata = '0;
  assign busy      = busy_q;

  assign end_cnt = (op_q == OP_COPY) ? ({1'b0, last_q} + CNT_W'(1)) : {1'b0, last_q};
  assign done    = cnt_q == end_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) colour_q <= '0;
    else if (latch_go) colour_q <= reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      op_q      <= OP_STIP;
      cnt_q     <= '0;
      last_q    <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      mask_q    <= '0;
      run_col_q <= '0;
    end else if (cmd_go) begin
      busy_q    <= 1'b1;
      cnt_q     <= '0;
      dst_q     <= reg_addr[3 +: PIX_AW];
      src_q     <= reg_wdata[PIX_AW-1:0];
      mask_q    <= reg_wdata;
      run_col_q <= colour_q;
      if (!reg_win) begin
        op_q   <= OP_STIP;
        last_q <= 5'd31;
      end else begin
        op_q   <= (reg_wdata[23:0] == FILL_KEY) ? OP_FILL : OP_COPY;
        last_q <= reg_wdata[28:24];
      end
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      mask_q <= mask_q << 1;
      if (done) busy_q <= 1'b0;
    end
  end

  assign mem_ren   = busy_q && (op_q == OP_COPY) && !done;
  assign mem_raddr = src_q + PIX_AW'(cnt_q);
  assign mem_wen   = busy_q && ((op_q == OP_STIP) ? mask_q[31] :
                                (op_q == OP_FILL) ? 1'b1 : (cnt_q != '0));
  assign mem_waddr = dst_q + PIX_AW'((op_q == OP_COPY) ? (cnt_q - CNT_W'(1)) : cnt_q);
  assign mem_wdata = (op_q != OP_COPY) ? run_col_q : (fwd_q ? fwd_d_q : mem_rdata);

  // a read that hits the pixel written in the same cycle must see the new byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q   <= 1'b0;
      fwd_d_q <= '0;
    end else begin
      fwd_q   <= mem_ren && mem_wen && (mem_raddr == mem_waddr);
      fwd_d_q <= mem_wdata;
    end
  end

  p_cmd_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[2] && reg_be == 4'hF && reg_ready) |=> busy);

  p_partial_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_be != 4'hF) |=> !busy);

  p_seq_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && $past(mem_wen)) |-> (mem_waddr == $past(mem_waddr) + PIX_AW'(1)));

  p_mem_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!mem_wen && !mem_ren));

  p_run_colour_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && !mem_ren && $past(mem_wen) && $past(!mem_ren) && op_q != OP_COPY)
      |-> $stable(mem_wdata));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr[2]) |=> busy || $past(done));

endmodule

// File: tb/raster_engine_tb_top.sv
`timescale 1ns/1ps
module raster_engine_tb_top;
  localparam int AW = 10, N = 1 << AW, RAW = 23;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, reg_wr, reg_win, reg_ready, busy, mem_ren, mem_wen;
  logic [RAW-1:0] reg_addr;
  logic [3:0] reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [7:0] mem_rdata, mem_wdata, rdq;
  logic [7:0] ram [N];
  logic [7:0] ref_m [N];
  logic [7:0] ref_col;
  int vecs = 0, errs = 0;

  raster_engine #(.PIX_AW(AW), .REG_AW(RAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_win(reg_win), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .busy(busy), .mem_ren(mem_ren), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_wen(mem_wen), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata));

  always @(posedge clk) begin
    if (mem_wen) ram[mem_waddr] <= mem_wdata;
    if (mem_ren) rdq <= ram[mem_raddr];
  end
  assign mem_rdata = rdq;

  task automatic chk(string rq, int act, int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic cmp_mem(string rq);
    int bad = -1;
    vecs++;
    for (int i = 0; i < N; i++) if (bad < 0 && ram[i] !== ref_m[i]) bad = i;
    if (bad >= 0) begin
      errs++;
      $display("FAIL %s: pixel %0d actual %0h expected %0h", rq, bad, ram[bad], ref_m[bad]);
    end
  endtask

  task automatic put(bit win, int pix, bit cmd, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_win = win; reg_be = be; reg_wdata = d;
    reg_addr = RAW'((pix << 3) | (cmd ? 4 : 0));
    #1;
    while (!reg_ready) @(negedge clk);
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic run_wait(output int cyc);
    cyc = 0;
    @(negedge clk);
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic set_col(logic [7:0] c);
    put(c[0], 0, 1'b0, 4'hF, {c ^ 8'h5A, 16'hBEEF, c});
    ref_col = c;
  endtask

  task automatic do_stip(int pix, logic [31:0] mask);
    int c;
    put(1'b0, pix, 1'b1, 4'hF, mask);
    run_wait(c);
    chk("R3 stipple busy cycles", c, 32);
    for (int i = 0; i < 32; i++) if (mask[31-i]) ref_m[(pix + i) % N] = ref_col;
    cmp_mem("R3 stipple pixels");
  endtask

  task automatic do_blit(int pix, int len, int src);
    int c;
    logic [31:0] d;
    d = {3'b0, 5'(len - 1), 24'(src)};
    put(1'b1, pix, 1'b1, 4'hF, d);
    run_wait(c);
    if (d[23:0] == 24'hFFFFFF) begin
      chk("R5 fill busy cycles", c, len);
      for (int i = 0; i < len; i++) ref_m[(pix + i) % N] = ref_col;
      cmp_mem("R5 fill pixels");
    end else begin
      chk("R6 copy busy cycles", c, len + 1);
      for (int i = 0; i < len; i++) ref_m[(pix + i) % N] = ref_m[(src + i) % N];
      cmp_mem("R6 copy pixels");
    end
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    int c;
    rst_n = 1'b0; reg_wr = 1'b0; reg_win = 1'b0; reg_addr = '0; reg_be = '0; reg_wdata = '0;
    for (int i = 0; i < N; i++) begin ram[i] = 8'(i * 37 + 5); ref_m[i] = 8'(i * 37 + 5); end
    ref_col = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = RAW'(4);
    #1;
    chk("R9 reset busy", busy, 0);
    chk("R9 reset ready", reg_ready, 1);
    chk("R9 reset no write", mem_wen, 0);
    chk("R8 rdata", reg_rdata, 0);

    // R1: colour latch writes nothing
    set_col(8'hC3);
    repeat (2) @(negedge clk);
    cmp_mem("R1 latch draws nothing");
    chk("R1 no busy after latch", busy, 0);

    // R3 stipple sweep; R2/R10 destinations with high bits and wrap
    lfsr = 32'h1234_5678;
    foreach (lfsr[k]) begin end
    for (int di = 0; di < 4; di++) begin
      int dst;
      dst = (di == 0) ? 0 : (di == 1) ? 77 : (di == 2) ? 1015 : 20'hFFC05;
      for (int m = 0; m < 7; m++) begin
        logic [31:0] mask;
        case (m)
          0: mask = 32'h0000_0000;
          1: mask = 32'hFFFF_FFFF;
          2: mask = 32'hA5A5_5A5A;
          3: mask = 32'h8000_0001;
          4: mask = 32'h0000_0080;
          default: begin lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; mask = lfsr * 32'h9E37_79B9; end
        endcase
        set_col(8'(m * 41 + di));
        do_stip(dst, mask);
      end
    end

    // R4/R5 fill sweep over every length
    for (int len = 1; len <= 32; len++) begin
      set_col(8'(len * 13));
      do_blit(len * 29, len, 24'hFFFFFF);
    end
    set_col(8'h66);
    do_blit(20'hFFFF0, 32, 24'hFFFFFF);   // R10 wrap of fill

    // R6 copies, overlapping and disjoint; R10 source wrap
    for (int li = 0; li < 5; li++) begin
      int len;
      len = (li == 0) ? 1 : (li == 1) ? 2 : (li == 2) ? 7 : (li == 3) ? 31 : 32;
      do_blit(300, len, 299);              // dest = src+1 replicates
      do_blit(400, len, 401);              // dest = src-1 shifts down
      do_blit(500, len, 497);              // dest = src+3
      do_blit(700, len, 100 + li);         // disjoint
      do_blit(1010, len, 24'h00FC00 + 3);  // wrapped source and dest
    end
    do_blit(50, 4, 24'hFFFFFE);            // R5 key must match exactly: copy from 1022

    // R7 partial byte enables are ignored
    set_col(8'h11);
    put(1'b0, 0, 1'b0, 4'h3, 32'h0000_0077);
    put(1'b1, 200, 1'b1, 4'h7, {8'h1F, 24'hFFFFFF});
    @(negedge clk);
    chk("R7 partial command not started", busy, 0);
    cmp_mem("R7 partial writes leave memory");
    do_blit(200, 3, 24'hFFFFFF);           // uses colour 0x11, not 0x77

    // R9 backpressure and colour isolation during a run
    set_col(8'h2B);
    put(1'b1, 600, 1'b1, 4'hF, {8'h1F, 24'hFFFFFF});
    @(negedge clk);
    reg_addr = RAW'((650 << 3) | 4);
    #1;
    chk("R9 busy during run", busy, 1);
    chk("R9 command stalled", reg_ready, 0);
    reg_addr = RAW'(650 << 3);
    #1;
    chk("R9 colour accepted", reg_ready, 1);
    chk("R8 rdata while busy", reg_rdata, 0);
    put(1'b1, 0, 1'b0, 4'hF, 32'h0000_0044);
    chk("R9 colour write taken while busy", busy, 1);
    run_wait(c);
    for (int i = 0; i < 32; i++) ref_m[600 + i] = 8'h2B;
    cmp_mem("R9 run used colour from start");
    ref_col = 8'h44;
    do_blit(650, 5, 24'hFFFFFF);
    // stalled command is taken after the run ends
    put(1'b1, 800, 1'b1, 4'hF, {8'h07, 24'hFFFFFF});
    put(1'b1, 820, 1'b1, 4'hF, {8'h03, 24'hFFFFFF});
    run_wait(c);
    for (int i = 0; i < 8; i++) ref_m[800 + i] = 8'h44;
    for (int i = 0; i < 4; i++) ref_m[820 + i] = 8'h44;
    cmp_mem("R9 stalled command completes");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule